// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a leaf page table entry by reading page table entries from memory one level at a time. A translation cache sends it a request with the virtual address, a flag that says whether translation is on, the root table base and the size of physical memory. The walker answers with one 64-bit entry. An answer of zero means the translation failed. Permission checks stay with the requester.

When translation is off, the walker builds an identity-mapped entry straight from the address and reads no memory. When translation is on, it walks downward from the root. A valid entry found above the last level is a superpage. For that case the walker returns an equivalent small-page entry, with the virtual page bits that the superpage covers merged into the physical page number. Every table fetch address and every final physical address is checked against the memory size.

Entry encoding used throughout: bit 0 is the table (pointer) bit and bit 1 is the leaf-valid bit. Bits `PERM_LSB` and up, `PERM_W` wide (default bits 7:2), hold permissions. The physical page number starts at bit `PPN_LSB` (default 10). If both bit 0 and bit 1 are set, the leaf bit wins.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken when `req_valid` and `req_ready` are both high. Each request gets exactly one result, shown by a single-cycle `resp_valid` pulse, and `req_ready` stays low until that pulse.
- R2: With `vm_on` low and an address below `mem_size`, the result has bit 1 set, bit 0 clear, every permission bit set, and a PPN equal to the address shifted right by `PG_SHIFT`. No memory read is issued.
- R3: With `vm_on` low and an address at or above `mem_size`, the result is zero.
- R4: The walk starts with base = `root_base`. At level L (0 = first), the index is `(vaddr >> (PG_SHIFT + (LEVELS-1-L)*IDX_BITS))` masked to `IDX_BITS` bits. The fetch address is base + index × `PTE_BYTES`. An entry with bit 0 set and bit 1 clear sets the next base to its PPN << `PG_SHIFT`.
- R5: A fetch address at or above `mem_size` ends the walk with result zero, and that fetch is never issued.
- R6: A leaf (bit 1 set) found at the last level is returned unchanged when its physical address is in range.
- R7: A leaf found at an upper level is returned with the virtual page number bits below that level's shift ORed into its PPN.
- R8: A leaf whose (PPN << `PG_SHIFT`) + page offset, taken after the merge, is at or above `mem_size` gives result zero.
- R9: An entry with both bit 0 and bit 1 clear ends the walk with result zero.
- R10: A table entry at the last level (no levels left) gives result zero.
- R11: Only one memory read is outstanding at a time. `mem_req_valid` and `mem_req_addr` are held stable until `mem_req_ready`, and no new request is issued until `mem_rsp_valid` returns.
- R12: A non-zero result always has bit 1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | XLEN | Virtual address to translate |
| vm_on | input | 1 | Translation enabled; low selects identity mapping |
| root_base | input | XLEN | Physical byte address of the root table |
| mem_size | input | XLEN | Size of physical memory in bytes |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_pte | output | XLEN | Resulting leaf entry, zero on failure |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | XLEN | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | XLEN | Entry read from memory |

## Verification
The bench builds the walker with three levels, 4 index bits and an 8-bit page shift, and sets memory to 64 KiB. With these values a complete walk fits in a 20-bit virtual address and a handful of table pages. That makes superpage leaves at both upper levels easy to reach, along with table pointers, fetch addresses and leaf addresses that sit exactly on the memory-size boundary. The memory model toggles its ready signal and answers with two cycles of latency, so request holding and the single-outstanding rule are exercised on every walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        WALK_IDLE  = 2'd0,
        WALK_ISSUE = 2'd1,
        WALK_WAIT  = 2'd2,
        WALK_DONE  = 2'd3
    } walk_state_e;

endpackage

// File: rtl/ptw_index_calc.sv
module ptw_index_calc #(
    parameter int XLEN      = 64,
    parameter int LEVELS    = 3,
    parameter int IDX_BITS  = 10,
    parameter int PG_SHIFT  = 13,
    parameter int PTE_BYTES = 8,
    parameter int LVL_W     = 2,
    parameter int SH_W      = 5
) (
    input  logic [XLEN-1:0]  vaddr,
    input  logic [XLEN-1:0]  base,
    input  logic [LVL_W-1:0] level,
    output logic [SH_W-1:0]  lvl_shift,
    output logic [XLEN-1:0]  pte_addr
);
    localparam int PTE_SH = $clog2(PTE_BYTES);
    localparam logic [XLEN-1:0] IDX_MASK = (XLEN'(1) << IDX_BITS) - XLEN'(1);

    logic [XLEN-1:0] idx;

    always_comb begin
        lvl_shift = SH_W'((LEVELS - 1 - int'(level)) * IDX_BITS);
        idx       = (vaddr >> (XLEN'(PG_SHIFT) + XLEN'(lvl_shift))) & IDX_MASK;
        pte_addr  = base + (idx << PTE_SH);
    end
endmodule

// File: rtl/ptw_leaf_merge.sv
module ptw_leaf_merge #(
    parameter int XLEN     = 64,
    parameter int PG_SHIFT = 13,
    parameter int PPN_LSB  = 10,
    parameter int SH_W     = 5
) (
    input  logic [XLEN-1:0] vaddr,
    input  logic [XLEN-1:0] pte_in,
    input  logic [SH_W-1:0] lvl_shift,
    input  logic [XLEN-1:0] mem_size,
    output logic [XLEN-1:0] pte_out,
    output logic            fits
);
    localparam logic [XLEN-1:0] PG_MASK = (XLEN'(1) << PG_SHIFT) - XLEN'(1);

    logic [XLEN-1:0] vpn_low;
    logic [XLEN-1:0] ppn;
    logic [XLEN-1:0] phys;

    always_comb begin
        vpn_low = (vaddr >> PG_SHIFT) & ((XLEN'(1) << lvl_shift) - XLEN'(1));
        pte_out = pte_in | (vpn_low << PPN_LSB);
        ppn     = pte_out >> PPN_LSB;
        phys    = (ppn << PG_SHIFT) + (vaddr & PG_MASK);
        fits    = phys < mem_size;
    end
endmodule

// File: rtl/ptw_bypass_map.sv
module ptw_bypass_map #(
    parameter int XLEN     = 64,
    parameter int PG_SHIFT = 13,
    parameter int PPN_LSB  = 10,
    parameter int LEAF_BIT = 1,
    parameter int PERM_LSB = 2,
    parameter int PERM_W   = 6
) (
    input  logic [XLEN-1:0] vaddr,
    input  logic [XLEN-1:0] mem_size,
    output logic [XLEN-1:0] pte
);
    localparam logic [XLEN-1:0] PERM_ALL = ((XLEN'(1) << PERM_W) - XLEN'(1)) << PERM_LSB;
    localparam logic [XLEN-1:0] LEAF_M   = XLEN'(1) << LEAF_BIT;

    always_comb begin
        if (vaddr < mem_size)
            pte = LEAF_M | PERM_ALL | ((vaddr >> PG_SHIFT) << PPN_LSB);
        else
            pte = '0;
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int LEVELS    = 3,
    parameter int IDX_BITS  = 10,
    parameter int PG_SHIFT  = 13,
    parameter int PTE_BYTES = 8,
    parameter int TABLE_BIT = 0,
    parameter int LEAF_BIT  = 1,
    parameter int PERM_LSB  = 2,
    parameter int PERM_W    = 6,
    parameter int PPN_LSB   = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [XLEN-1:0] req_vaddr,
    input  logic            vm_on,
    input  logic [XLEN-1:0] root_base,
    input  logic [XLEN-1:0] mem_size,
    output logic            resp_valid,
    output logic [XLEN-1:0] resp_pte,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [XLEN-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_data
);
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int SH_W  = $clog2(LEVELS * IDX_BITS + 1);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    typedef struct packed {
        walk_state_e     st;
        logic [LVL_W-1:0] level;
        logic [XLEN-1:0] base;
        logic [XLEN-1:0] vaddr;
        logic [XLEN-1:0] pte;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic [SH_W-1:0] lvl_shift;
    logic [XLEN-1:0] fetch_addr;
    logic [XLEN-1:0] leaf_pte;
    logic            leaf_fits;
    logic [XLEN-1:0] bypass_pte;
    logic            fetch_ok;

    ptw_index_calc #(
        .XLEN(XLEN), .LEVELS(LEVELS), .IDX_BITS(IDX_BITS), .PG_SHIFT(PG_SHIFT),
        .PTE_BYTES(PTE_BYTES), .LVL_W(LVL_W), .SH_W(SH_W)
    ) i_index (
        .vaddr(r_q.vaddr), .base(r_q.base), .level(r_q.level),
        .lvl_shift(lvl_shift), .pte_addr(fetch_addr)
    );

    ptw_leaf_merge #(
        .XLEN(XLEN), .PG_SHIFT(PG_SHIFT), .PPN_LSB(PPN_LSB), .SH_W(SH_W)
    ) i_leaf (
        .vaddr(r_q.vaddr), .pte_in(mem_rsp_data), .lvl_shift(lvl_shift),
        .mem_size(mem_size), .pte_out(leaf_pte), .fits(leaf_fits)
    );

    ptw_bypass_map #(
        .XLEN(XLEN), .PG_SHIFT(PG_SHIFT), .PPN_LSB(PPN_LSB), .LEAF_BIT(LEAF_BIT),
        .PERM_LSB(PERM_LSB), .PERM_W(PERM_W)
    ) i_bypass (
        .vaddr(req_vaddr), .mem_size(mem_size), .pte(bypass_pte)
    );

    assign fetch_ok = fetch_addr < mem_size;

    always_comb begin
        r_d           = r_q;
        req_ready     = (r_q.st == WALK_IDLE);
        resp_valid    = (r_q.st == WALK_DONE);
        resp_pte      = r_q.pte;
        mem_req_valid = (r_q.st == WALK_ISSUE) && fetch_ok;
        mem_req_addr  = fetch_addr;

        unique case (r_q.st)
            WALK_IDLE: begin
                if (req_valid) begin
                    r_d.vaddr = req_vaddr;
                    r_d.level = '0;
                    r_d.base  = root_base;
                    r_d.pte   = '0;
                    if (vm_on) begin
                        r_d.st = WALK_ISSUE;
                    end else begin
                        r_d.pte = bypass_pte;
                        r_d.st  = WALK_DONE;
                    end
                end
            end
            WALK_ISSUE: begin
                if (!fetch_ok) begin
                    r_d.pte = '0;
                    r_d.st  = WALK_DONE;
                end else if (mem_req_ready) begin
                    r_d.st = WALK_WAIT;
                end
            end
            WALK_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_data[LEAF_BIT]) begin
                        r_d.pte = leaf_fits ? leaf_pte : '0;
                        r_d.st  = WALK_DONE;
                    end else if (!mem_rsp_data[TABLE_BIT]) begin
                        r_d.pte = '0;
                        r_d.st  = WALK_DONE;
                    end else if (r_q.level == LAST_LVL) begin
                        r_d.pte = '0;
                        r_d.st  = WALK_DONE;
                    end else begin
                        r_d.base  = (mem_rsp_data >> PPN_LSB) << PG_SHIFT;
                        r_d.level = r_q.level + LVL_W'(1);
                        r_d.st    = WALK_ISSUE;
                    end
                end
            end
            WALK_DONE: begin
                r_d.st = WALK_IDLE;
            end
            default: r_d.st = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= WALK_IDLE;
            r_q.level <= '0;
            r_q.base  <= '0;
            r_q.vaddr <= '0;
            r_q.pte   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R1
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && mem_req_valid));

    // R1
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R5
    fetch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr < mem_size));

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R11
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    // R12
    leaf_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && (resp_pte != '0)) |-> resp_pte[LEAF_BIT]);
endmodule

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 64;
    localparam int LV = 3;
    localparam int IB = 4;
    localparam int PS = 8;
    localparam logic [63:0] MSIZE = 64'h1_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [63:0] req_vaddr = '0;
    logic vm_on = 1'b0;
    logic [63:0] root_base = '0;
    logic resp_valid;
    logic [63:0] resp_pte;
    logic mem_req_valid;
    logic mem_req_ready;
    logic [63:0] mem_req_addr;
    logic mem_rsp_valid;
    logic [63:0] mem_rsp_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_walker #(.XLEN(XLEN), .LEVELS(LV), .IDX_BITS(IB), .PG_SHIFT(PS)) i_ptw_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .vm_on(vm_on), .root_base(root_base), .mem_size(MSIZE),
        .resp_valid(resp_valid), .resp_pte(resp_pte),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    // memory model: toggling ready, two-cycle read latency
    logic [63:0] mem [longint];
    logic rdy = 1'b0;
    int pend = 0;
    logic [63:0] pend_addr = '0;
    int nreads = 0;
    logic [63:0] rlog [8];
    logic [63:0] rsp_d = '0;
    logic rsp_v = 1'b0;

    assign mem_req_ready = rdy;
    assign mem_rsp_valid = rsp_v;
    assign mem_rsp_data  = rsp_d;

    always @(posedge clk) begin
        if (!rst_n) begin
            rdy <= 1'b0; pend <= 0; rsp_v <= 1'b0;
        end else begin
            rdy   <= ~rdy;
            rsp_v <= 1'b0;
            if (pend != 0) begin
                pend <= pend - 1;
                if (pend == 1) begin
                    rsp_v <= 1'b1;
                    rsp_d <= mem.exists(longint'(pend_addr)) ? mem[longint'(pend_addr)] : 64'h0;
                end
            end
            if (mem_req_valid && mem_req_ready) begin
                pend_addr <= mem_req_addr;
                pend <= 2;
                rlog[nreads % 8] <= mem_req_addr;
                nreads <= nreads + 1;
            end
        end
    end

    // bit0 table, bit1 leaf, perm bits [7:2], PPN from bit 10
    function automatic logic [63:0] mk(input logic [63:0] ppn, input bit v, input bit t,
                                       input logic [5:0] perm);
        return (ppn << 10) | (64'(perm) << 2) | (64'(v) << 1) | 64'(t);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic walk(input bit vm, input logic [63:0] va, input logic [63:0] root,
                        output logic [63:0] pte, output int reads);
        int start;
        bit busy_ok = 1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        start = nreads;
        vm_on = vm; req_vaddr = va; root_base = root; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid) begin
            if (req_ready) busy_ok = 0;
            @(negedge clk);
        end
        pte = resp_pte;
        reads = nreads - start;
        @(negedge clk);
        check("R1 single pulse", {63'd0, resp_valid}, 64'd0);
        check("R1 ready low while busy", {63'd0, busy_ok}, 64'd1);
    endtask

    task automatic t_reset();
        check("R1 reset ready", {63'd0, req_ready}, 64'd1);
        check("R1 reset resp", {63'd0, resp_valid}, 64'd0);
        check("R11 reset mem req", {63'd0, mem_req_valid}, 64'd0);
    endtask

    task automatic t_bypass();
        logic [63:0] p; int n;
        walk(0, 64'h1234, 64'h100, p, n);
        check("R2 bypass pte", p, mk(64'h12, 1, 0, 6'h3F));
        check("R2 bypass no read", 64'(n), 64'd0);
        walk(0, 64'hFFFF, 64'h100, p, n);
        check("R2 bypass top", p, mk(64'hFF, 1, 0, 6'h3F));
        walk(0, 64'h1_0000, 64'h100, p, n);
        check("R3 bypass out of range", p, 64'd0);
    endtask

    task automatic t_full_walk();
        logic [63:0] p; int n;
        mem[64'h118] = mk(64'h2, 0, 1, 6'h0);
        mem[64'h228] = mk(64'h3, 0, 1, 6'h0);
        mem[64'h338] = mk(64'h40, 1, 0, 6'h15);
        walk(1, 64'h357AB, 64'h100, p, n);
        check("R6 last level leaf", p, mk(64'h40, 1, 0, 6'h15));
        check("R4 three reads", 64'(n), 64'd3);
        check("R4 first fetch", rlog[(nreads-3) % 8], 64'h118);
        check("R4 second fetch", rlog[(nreads-2) % 8], 64'h228);
        check("R4 third fetch", rlog[(nreads-1) % 8], 64'h338);
    endtask

    task automatic t_superpage();
        logic [63:0] p; int n;
        mem[64'h228] = mk(64'h50, 1, 0, 6'h03);
        walk(1, 64'h357AB, 64'h100, p, n);
        check("R7 level1 superpage", p, mk(64'h57, 1, 0, 6'h03));
        check("R7 level1 reads", 64'(n), 64'd2);
        mem[64'h118] = mk(64'h0, 1, 0, 6'h01);
        walk(1, 64'h357AB, 64'h100, p, n);
        check("R7 level0 superpage", p, mk(64'h57, 1, 0, 6'h01));
        mem[64'h118] = mk(64'h100, 1, 0, 6'h01);
        walk(1, 64'h357AB, 64'h100, p, n);
        check("R8 superpage beyond memory", p, 64'd0);
    endtask

    task automatic t_leaf_bound();
        logic [63:0] p; int n;
        mem[64'h118] = mk(64'h2, 0, 1, 6'h0);
        mem[64'h228] = mk(64'h3, 0, 1, 6'h0);
        mem[64'h338] = mk(64'hFF, 1, 1, 6'h02);
        walk(1, 64'h357FF, 64'h100, p, n);
        check("R8 last byte in range", p, mk(64'hFF, 1, 1, 6'h02));
        mem[64'h338] = mk(64'h100, 1, 0, 6'h02);
        walk(1, 64'h35700, 64'h100, p, n);
        check("R8 first byte out of range", p, 64'd0);
    endtask

    task automatic t_bad_entries();
        logic [63:0] p; int n;
        mem[64'h338] = mk(64'h40, 0, 0, 6'h3F);
        walk(1, 64'h357AB, 64'h100, p, n);
        check("R9 invalid entry", p, 64'd0);
        check("R9 reads", 64'(n), 64'd3);
        mem[64'h338] = mk(64'h4, 0, 1, 6'h0);
        walk(1, 64'h357AB, 64'h100, p, n);
        check("R10 levels exhausted", p, 64'd0);
        check("R10 no fourth read", 64'(n), 64'd3);
    endtask

    task automatic t_fetch_range();
        logic [63:0] p; int n;
        walk(1, 64'h357AB, 64'hFFF8, p, n);
        check("R5 fetch beyond memory", p, 64'd0);
        check("R5 no read issued", 64'(n), 64'd0);
        mem[64'hFFF8] = 64'd0;
        walk(1, 64'h357AB, 64'hFFE0, p, n);
        check("R5 last word fetched", 64'(n), 64'd1);
        check("R5 last word addr", rlog[(nreads-1) % 8], 64'hFFF8);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_full_walk();
        t_superpage();
        t_leaf_bound();
        t_bad_entries();
        t_fetch_range();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule